// File: doc/BRIEF.md
# Answer-Tone Disabler Controller

This block decides when one echo-canceller channel has to be bypassed because a modem answer tone is on the line. An external tone analyser does the frequency, level, phase and power estimation. It presents four per-sample qualifiers to this block: tone in band (2075 to 2125 Hz), tone level at or above -32 dBm0, a phase-reversal event of 135 to 225 degrees, and received power below -32 dBm0. A one-clock sample strobe at the 8 kHz sample rate accompanies them. All timing is counted in strobes. The block drives one flag: high means the canceller is disabled, low means it runs.

A two-bit mode selects the detection rule. The first rule accepts a continuous qualified tone. The second accepts only a tone whose phase flips at a regular spacing. After the flag rises it stays latched, whatever the tone inputs do. It falls only after the received power has stayed low for the release time. The qualifier pins are plain level inputs and have no handshake: they are valid in the clock cycle where the strobe is high, and they are ignored in every other cycle. The block has no storage, so there is no back-pressure.

Top module: `answer_tone_disabler`

## Requirements
- R1: Mode encoding on `mode_sel`: 2'b00 is off, 2'b01 accepts any qualified tone, 2'b10 accepts only a phase-reversing tone, and 2'b11 is illegal and behaves as off. If a strobe arrives in off or illegal mode, the flag is low after that strobe, even if it was high before.
- R2: A strobe counts as qualified only when `tone_in_band` and `tone_lvl_ok` are both high.
- R3: In mode 2'b01 the flag rises on the clock edge of the 3040th consecutive qualified strobe, and not earlier.
- R4: In mode 2'b01 an unqualified strobe before detection completes sets the detection count back to zero.
- R5: In mode 2'b10 a steady qualified tone without reversals never raises the flag. The flag rises on the reversal strobe that completes two consecutive accepted intervals. An interval is the number of strobes from one reversal strobe to the next.
- R6: An interval is accepted when it lies from 3400 to 3800 strobes inclusive. A reversal that comes earlier discards the accepted intervals and becomes the new reference. If no reversal comes within 3800 strobes, tracking is dropped, and the next reversal is treated as a first one.
- R7: Once the flag is high, it stays high whatever the tone, level and reversal inputs do, as long as the mode stays legal and the release condition has not been met.
- R8: The flag falls on the clock edge of the 2000th consecutive strobe with `pwr_low` high. Any strobe with `pwr_low` low restarts this count.
- R9: Inputs are sampled only when `smp_stb` is high. The flag changes only on the clock edge where a strobe is present.
- R10: While `rst_n` is low, the flag is low and all detection and release state is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous channel reset |
| smp_stb | input | 1 | One-clock strobe per sample period |
| mode_sel | input | 2 | Detection mode select |
| tone_in_band | input | 1 | Tone frequency inside the answer-tone band |
| tone_lvl_ok | input | 1 | Tone level at or above the detection level |
| phase_rev | input | 1 | Phase reversal seen in this sample |
| pwr_low | input | 1 | Received power below the release level |
| bypass_flag | output | 1 | High: canceller disabled; low: canceller enabled |

## Verification
The hardest case to reach is the interval window edges in reversal mode. The flag only rises after two accepted intervals in a row, so a single misjudged interval shows up only at the end of a run of several thousand strobes. The bench places reversal strobes at exact strobe counts: 3400 and 3800 to prove the edges are accepted, 3399 to prove that an early reversal discards an interval already accepted, and 3801 to prove that a late reversal becomes a fresh reference. It then checks that one further good interval is not enough and that a second one is.

// File: rtl/atd_pkg.sv
package atd_pkg;

  typedef enum logic [1:0] {
    ATD_OFF   = 2'b00,
    ATD_ANY   = 2'b01,
    ATD_PHASE = 2'b10,
    ATD_BAD   = 2'b11
  } atd_mode_e;

  typedef enum logic {
    ST_WATCH  = 1'b0,
    ST_BYPASS = 1'b1
  } atd_state_e;

  // True for the two modes that run detection.
  function automatic logic mode_live(input logic [1:0] m);
    return (m == ATD_ANY) || (m == ATD_PHASE);
  endfunction

endpackage

// File: rtl/atd_run_timer.sv
// Counts consecutive strobes on which run is high; hit marks the LIMIT-th one.
module atd_run_timer #(
  parameter int LIMIT = 3040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic run,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign hit = stb && run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (stb) begin
      if (run && !hit) cnt <= cnt + 1'b1;
      else             cnt <= '0;
    end
  end
endmodule

// File: rtl/atd_rev_tracker.sv
// Measures spacing between phase-reversal strobes and counts accepted intervals.
module atd_rev_tracker #(
  parameter int GAP_MIN = 3400,
  parameter int GAP_MAX = 3800,
  parameter int NEED    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic active,
  input  logic rev,
  output logic hit
);
  localparam int GW = $clog2(GAP_MAX + 1);
  localparam int NW = $clog2(NEED + 1);

  logic          armed;
  logic [GW-1:0] gap;
  logic [GW-1:0] gap_inc;
  logic [NW-1:0] good;
  logic          in_win;

  assign gap_inc = gap + 1'b1;
  assign in_win  = (gap_inc >= GW'(GAP_MIN)) && (gap_inc <= GW'(GAP_MAX));
  assign hit     = stb && active && rev && armed && in_win &&
                   (good == NW'(NEED - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      gap   <= '0;
      good  <= '0;
    end else if (stb) begin
      if (!active) begin
        armed <= 1'b0;
        gap   <= '0;
        good  <= '0;
      end else if (rev) begin
        gap <= '0;
        if (!armed) begin
          armed <= 1'b1;
          good  <= '0;
        end else if (in_win) begin
          good <= hit ? '0 : good + 1'b1;
        end else begin
          good <= '0;               // early reversal: new reference
        end
      end else if (armed) begin
        if (gap_inc >= GW'(GAP_MAX)) begin
          armed <= 1'b0;            // window closed without a reversal
          gap   <= '0;
          good  <= '0;
        end else begin
          gap <= gap_inc;
        end
      end
    end
  end
endmodule

// File: rtl/atd_flag_fsm.sv
// Two-state latch: watching for a tone, or holding the canceller bypassed.
module atd_flag_fsm
  import atd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb,
  input  logic [1:0] mode,
  input  logic       det_hit,
  input  logic       rel_hit,
  output atd_state_e state
);
  atd_state_e state_nx;

  always_comb begin
    state_nx = state;
    if (stb) begin
      if (!mode_live(mode)) begin
        state_nx = ST_WATCH;
      end else begin
        unique case (state)
          ST_WATCH:  if (det_hit) state_nx = ST_BYPASS;
          ST_BYPASS: if (rel_hit) state_nx = ST_WATCH;
          default:   state_nx = ST_WATCH;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_WATCH;
    else        state <= state_nx;
  end
endmodule

// File: rtl/answer_tone_disabler.sv
module answer_tone_disabler
  import atd_pkg::*;
#(
  parameter int DETECT_SAMPLES  = 3040,
  parameter int RELEASE_SAMPLES = 2000,
  parameter int REV_GAP_MIN     = 3400,
  parameter int REV_GAP_MAX     = 3800,
  parameter int REV_INTERVALS   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_stb,
  input  logic [1:0] mode_sel,
  input  logic       tone_in_band,
  input  logic       tone_lvl_ok,
  input  logic       phase_rev,
  input  logic       pwr_low,
  output logic       bypass_flag
);
  atd_state_e state;
  logic       watching;
  logic       qual;
  logic       any_hit;
  logic       rev_hit;
  logic       rel_hit;

  assign watching = (state == ST_WATCH);
  assign qual     = tone_in_band && tone_lvl_ok;

  atd_run_timer #(.LIMIT(DETECT_SAMPLES)) u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (smp_stb),
    .run   (watching && (mode_sel == ATD_ANY) && qual),
    .hit   (any_hit)
  );

  atd_rev_tracker #(
    .GAP_MIN (REV_GAP_MIN),
    .GAP_MAX (REV_GAP_MAX),
    .NEED    (REV_INTERVALS)
  ) u_rev (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (smp_stb),
    .active (watching && (mode_sel == ATD_PHASE) && qual),
    .rev    (phase_rev),
    .hit    (rev_hit)
  );

  atd_run_timer #(.LIMIT(RELEASE_SAMPLES)) u_release (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (smp_stb),
    .run   (!watching && mode_live(mode_sel) && pwr_low),
    .hit   (rel_hit)
  );

  atd_flag_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (smp_stb),
    .mode    (mode_sel),
    .det_hit (any_hit || rev_hit),
    .rel_hit (rel_hit),
    .state   (state)
  );

  assign bypass_flag = (state == ST_BYPASS);
endmodule

// File: rtl/atd_checker.sv
module atd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_stb,
  input logic [1:0] mode_sel,
  input logic       tone_in_band,
  input logic       tone_lvl_ok,
  input logic       phase_rev,
  input logic       pwr_low,
  input logic       bypass_flag
);
  AST_OFF_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && (mode_sel == 2'b00 || mode_sel == 2'b11) |=> !bypass_flag); // R1

  AST_RISE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_flag) |-> $past(smp_stb && tone_in_band && tone_lvl_ok)); // R2

  AST_PHASE_RISE_ON_REV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_flag) && $past(mode_sel == 2'b10) |-> $past(phase_rev)); // R5

  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_flag) |-> $past(pwr_low) || $past(mode_sel == 2'b00 || mode_sel == 2'b11)); // R8

  AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(bypass_flag)); // R9
endmodule

bind answer_tone_disabler atd_checker u_atd_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .smp_stb      (smp_stb),
  .mode_sel     (mode_sel),
  .tone_in_band (tone_in_band),
  .tone_lvl_ok  (tone_lvl_ok),
  .phase_rev    (phase_rev),
  .pwr_low      (pwr_low),
  .bypass_flag  (bypass_flag)
);

// File: tb/tb_answer_tone_disabler.sv
module tb_answer_tone_disabler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_stb = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       tone_in_band = 1'b0;
  logic       tone_lvl_ok = 1'b0;
  logic       phase_rev = 1'b0;
  logic       pwr_low = 1'b0;
  logic       bypass_flag;

  int n_tests = 0;
  int n_fail  = 0;
  int gap_clocks = 0;

  always #4 clk = ~clk;

  answer_tone_disabler dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_stb      (smp_stb),
    .mode_sel     (mode_sel),
    .tone_in_band (tone_in_band),
    .tone_lvl_ok  (tone_lvl_ok),
    .phase_rev    (phase_rev),
    .pwr_low      (pwr_low),
    .bypass_flag  (bypass_flag)
  );

  task automatic chk(input string req, input logic exp);
    n_tests++;
    if (bypass_flag !== exp) begin
      n_fail++;
      $display("FAIL %s: bypass_flag=%0b expected %0b at %0t", req, bypass_flag, exp, $time);
    end
  endtask

  task automatic flip_inputs();
    tone_in_band = ~tone_in_band;
    tone_lvl_ok  = ~tone_lvl_ok;
    pwr_low      = ~pwr_low;
    phase_rev    = ~phase_rev;
    mode_sel     = ~mode_sel;
  endtask

  // n strobes with the present inputs; in gap clocks the inputs are scrambled.
  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      smp_stb = 1'b1;
      @(negedge clk);
      smp_stb = 1'b0;
      for (int g = 0; g < gap_clocks; g++) begin
        flip_inputs();
        @(negedge clk);
        flip_inputs();
      end
    end
  endtask

  task automatic send_rev();
    phase_rev = 1'b1;
    pulse(1);
    phase_rev = 1'b0;
  endtask

  task automatic set_qual(input logic [1:0] m);
    mode_sel = m; tone_in_band = 1'b1; tone_lvl_ok = 1'b1; pwr_low = 1'b0; phase_rev = 1'b0;
  endtask

  task automatic release_all(input string req);
    tone_in_band = 1'b0; tone_lvl_ok = 1'b0; pwr_low = 1'b1;
    pulse(2000);
    pwr_low = 1'b0;
    chk(req, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 reset state", 1'b0);
  endtask

  task automatic t_any_tone();   // R3, R9: scrambled inputs between strobes
    set_qual(2'b01);
    gap_clocks = 1;
    pulse(3039);
    chk("R3/R9 before 3040th strobe", 1'b0);
    pulse(1);
    chk("R3/R9 at 3040th strobe", 1'b1);
    gap_clocks = 0;
  endtask

  task automatic t_hold();       // R7
    tone_in_band = 1'b0; tone_lvl_ok = 1'b0; pwr_low = 1'b0;
    pulse(500);
    chk("R7 held with tone gone", 1'b1);
    tone_in_band = 1'b1; phase_rev = 1'b1;
    pulse(300);
    phase_rev = 1'b0;
    chk("R7 held with other tone inputs", 1'b1);
  endtask

  task automatic t_release();    // R8
    tone_in_band = 1'b0; tone_lvl_ok = 1'b0;
    pwr_low = 1'b1; pulse(1000);
    pwr_low = 1'b0; pulse(1);
    pwr_low = 1'b1; pulse(1999);
    chk("R8 restart after interruption", 1'b1);
    pulse(1);
    chk("R8 release at 2000th low strobe", 1'b0);
    pwr_low = 1'b0;
  endtask

  task automatic t_dropout();    // R4
    set_qual(2'b01);
    pulse(3000);
    tone_lvl_ok = 1'b0; pulse(1); tone_lvl_ok = 1'b1;
    pulse(3039);
    chk("R4 count restarted after dropout", 1'b0);
    pulse(1);
    chk("R4 detect after full restart", 1'b1);
    release_all("R8 release after R4 test");
  endtask

  task automatic t_off_modes();  // R1, R2
    set_qual(2'b00); pulse(3100);
    chk("R1 mode 00 off", 1'b0);
    set_qual(2'b11); pulse(3100);
    chk("R1 mode 11 as off", 1'b0);
    set_qual(2'b01); tone_lvl_ok = 1'b0; pulse(3100);
    chk("R2 band without level", 1'b0);
    set_qual(2'b01); tone_in_band = 1'b0; pulse(3100);
    chk("R2 level without band", 1'b0);
  endtask

  task automatic t_off_clears(); // R1
    set_qual(2'b01); pulse(3040);
    chk("R3 detect before off", 1'b1);
    mode_sel = 2'b11; pulse(1);
    chk("R1 illegal mode drops flag", 1'b0);
  endtask

  task automatic t_phase_basic(); // R5
    set_qual(2'b10); pulse(4000);
    chk("R5 steady tone ignored", 1'b0);
    send_rev(); pulse(3599); send_rev();
    chk("R5 one interval not enough", 1'b0);
    pulse(3599); send_rev();
    chk("R5 two intervals of 3600", 1'b1);
    release_all("R8 release after R5 test");
  endtask

  task automatic t_phase_edges(); // R6
    set_qual(2'b10);
    send_rev(); pulse(3399); send_rev();
    pulse(3799); send_rev();
    chk("R6 intervals 3400 and 3800 accepted", 1'b1);
    release_all("R8 release after R6 edges");
  endtask

  task automatic t_phase_early(); // R6
    set_qual(2'b10);
    send_rev(); pulse(3599); send_rev();
    pulse(3398); send_rev();
    pulse(3599); send_rev();
    chk("R6 early reversal discards interval", 1'b0);
    pulse(3599); send_rev();
    chk("R6 detect after early reference", 1'b1);
    release_all("R8 release after R6 early");
  endtask

  task automatic t_phase_late(); // R6
    set_qual(2'b10);
    send_rev(); pulse(3599); send_rev();
    pulse(3800); send_rev();
    pulse(3599); send_rev();
    chk("R6 late reversal restarts tracking", 1'b0);
    pulse(3599); send_rev();
    chk("R6 detect after late reference", 1'b1);
    release_all("R8 release after R6 late");
  endtask

  task automatic t_reset_mid();  // R10
    set_qual(2'b01); pulse(3040);
    chk("R3 detect before reset", 1'b1);
    do_reset();
    chk("R10 reset clears flag", 1'b0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_any_tone();
    t_hold();
    t_release();
    t_dropout();
    t_off_modes();
    t_off_clears();
    t_phase_basic();
    t_phase_edges();
    t_phase_early();
    t_phase_late();
    t_reset_mid();
    finish_run();
  end
endmodule